// File: doc/BRIEF.md
# Cache-Block Operation Instruction Decoder

This block is a purely combinational decoder for 32-bit RISC-V instruction words. It picks out four cache-block maintenance operations: clean, flush, invalidate and zero. It also picks out the prefetch hints, which are ORI words that write x0. The cache-block operations share their major opcode and funct3 with the 128-bit quad-load instruction. Inside that shared slot, the fixed cache-block patterns take priority. Every other word in the slot falls through to quad-load.

Two enable inputs gate the two extension groups. The management enable covers clean, flush and invalidate. The zero enable covers zero. If a cache-block pattern matches but its group is disabled, the word is not treated as a cache-block operation. It is flagged illegal and does not fall through to quad-load.

The outputs are:
- a one-hot operation class,
- the rs1 register index of a recognised operation,
- a hint/no-op flag,
- a quad-load fall-through flag,
- an illegal-instruction flag.

A decode stage places this block beside its main decoder.

Top module: `cbo_op_decoder`

## Requirements
- R1: A word decodes as a cache-block operation only when all of these hold: opcode bits [6:0] = 0001111, funct3 bits [14:12] = 010, rd bits [11:7] = 00000 and bits [31:25] = 0000000. Bits [24:20] then choose the operation: 00001 is clean, 00010 is flush, 00000 is invalidate and 00100 is zero.
- R2: opClass has exactly one bit set for every input. The bit positions are: bit0 clean, bit1 flush, bit2 invalidate, bit3 zero, bit4 quad-load, bit5 other.
- R3: A word with opcode 0001111 and funct3 010 that matches none of the four fixed patterns sets opClass bit4 and quadLoad. This includes the zero-enable code 00100 when any other field is off-pattern.
- R4: When mgmtEn is 0, the clean, flush and invalidate patterns set illegalOp and opClass bit5. They clear quadLoad and set no cache-block class bit.
- R5: When zeroEn is 0, the zero pattern sets illegalOp and opClass bit5. The two enables are independent: clearing one never changes how the other group decodes.
- R6: rs1Idx equals bits [19:15] when one of opClass bits 0 to 3 is set, and is 0 otherwise.
- R7: An ORI word (opcode 0010011, funct3 110) with rd = 0 sets hintNop and opClass bit5, and never sets illegalOp. An ORI with a nonzero rd clears hintNop.
- R8: Any word outside the two opcode/funct3 slots gives opClass bit5 with hintNop, quadLoad and illegalOp all 0.
- R9: Clean and flush are both gated by mgmtEn alone. Each decodes to its own class bit whatever zeroEn is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instrWord | input | 32 | Instruction word to decode |
| mgmtEn | input | 1 | Enable for clean, flush and invalidate |
| zeroEn | input | 1 | Enable for cache-block zero |
| opClass | output | 6 | One-hot operation class |
| rs1Idx | output | 5 | Base-address register index of a recognised operation |
| hintNop | output | 1 | Prefetch hint; behaves as an ORI with no effect |
| quadLoad | output | 1 | Word falls through to the quad-load decoder |
| illegalOp | output | 1 | Cache-block pattern whose extension group is disabled |

## Verification
The immediate assertions are re-evaluated on every input change. They cover these structural properties:
- opClass is exactly one-hot;
- at most one fixed pattern matches;
- illegalOp never appears together with quadLoad;
- a hint never carries a cache-block or quad-load class;
- a nonzero rs1 index only comes with a recognised operation.

The bench scenarios cover the rest: that each specific encoding maps to the right class, that one-bit near misses fall through to quad-load, that each enable gates only its own group, and that rs1 is extracted correctly.

// File: rtl/cbo_dec_pkg.sv
package cbo_dec_pkg;
  localparam int ILEN_DEF   = 32;
  localparam int NUM_CBO    = 4;
  localparam int NUM_CLS    = NUM_CBO + 2;
  localparam int REG_W      = 5;
  localparam int OPC_LO     = 0;
  localparam int OPC_W      = 7;
  localparam int RD_LO      = 7;
  localparam int F3_LO      = 12;
  localparam int F3_W       = 3;
  localparam int RS1_LO     = 15;
  localparam int SEL_LO     = 20;
  localparam int TOP_LO     = 25;
  localparam int TOP_W      = 7;

  localparam logic [OPC_W-1:0] OPC_MISCMEM = 7'b0001111;
  localparam logic [OPC_W-1:0] OPC_OPIMM   = 7'b0010011;
  localparam logic [F3_W-1:0]  F3_CBO      = 3'b010;
  localparam logic [F3_W-1:0]  F3_ORI      = 3'b110;

  localparam int CLS_QLOAD = NUM_CBO;
  localparam int CLS_OTHER = NUM_CBO + 1;

  // Operation code in bits [24:20] for class index 0..3
  function automatic logic [REG_W-1:0] cboSelCode(input int idx);
    case (idx)
      0:       return 5'b00001;
      1:       return 5'b00010;
      2:       return 5'b00000;
      default: return 5'b00100;
    endcase
  endfunction

  function automatic logic cboUsesZeroGroup(input int idx);
    return (idx == 3);
  endfunction

  typedef struct packed {
    logic               slotHit;
    logic [NUM_CBO-1:0] patHit;
    logic [NUM_CBO-1:0] patEnabled;
    logic               oriHint;
  } cbo_strobe_t;
endpackage

// File: rtl/cbo_dec_ctrl.sv
module cbo_dec_ctrl
  import cbo_dec_pkg::*;
#(
  parameter int ILEN = ILEN_DEF
) (
  input  logic [ILEN-1:0] instrWord,
  input  logic            mgmtEn,
  input  logic            zeroEn,
  output cbo_strobe_t     strobes
);
  logic [OPC_W-1:0] opcField;
  logic [REG_W-1:0] rdField;
  logic [F3_W-1:0]  f3Field;
  logic [REG_W-1:0] selField;
  logic [TOP_W-1:0] topField;
  logic             fixedBase;

  assign opcField = instrWord[OPC_LO +: OPC_W];
  assign rdField  = instrWord[RD_LO +: REG_W];
  assign f3Field  = instrWord[F3_LO +: F3_W];
  assign selField = instrWord[SEL_LO +: REG_W];
  assign topField = instrWord[TOP_LO +: TOP_W];

  assign strobes.slotHit = (opcField == OPC_MISCMEM) && (f3Field == F3_CBO);
  assign fixedBase = strobes.slotHit && (rdField == '0) && (topField == '0);

  for (genvar g = 0; g < NUM_CBO; g++) begin : g_pat
    assign strobes.patHit[g]     = fixedBase && (selField == cboSelCode(g));
    if (cboUsesZeroGroup(g)) begin : g_zero
      assign strobes.patEnabled[g] = zeroEn;
    end else begin : g_mgmt
      assign strobes.patEnabled[g] = mgmtEn;
    end
  end

  assign strobes.oriHint = (opcField == OPC_OPIMM) && (f3Field == F3_ORI)
                           && (rdField == '0);

  always_comb begin
    assert_single_pattern_R1: assert ($onehot0(strobes.patHit))
      else $error("more than one fixed pattern matched");
    assert_pattern_in_slot_R1: assert (!(|strobes.patHit) || strobes.slotHit)
      else $error("fixed pattern outside its slot");
  end
endmodule

// File: rtl/cbo_dec_dp.sv
module cbo_dec_dp
  import cbo_dec_pkg::*;
#(
  parameter int ILEN = ILEN_DEF
) (
  input  logic [ILEN-1:0]    instrWord,
  input  cbo_strobe_t        strobes,
  output logic [NUM_CLS-1:0] opClass,
  output logic [REG_W-1:0]   rs1Idx,
  output logic               hintNop,
  output logic               quadLoad,
  output logic               illegalOp
);
  logic [NUM_CBO-1:0] liveOps;
  logic [NUM_CBO-1:0] blockedOps;
  logic               anyPattern;
  logic               fallThrough;

  assign liveOps     = strobes.patHit & strobes.patEnabled;
  assign blockedOps  = strobes.patHit & ~strobes.patEnabled;
  assign anyPattern  = |strobes.patHit;
  assign fallThrough = strobes.slotHit && !anyPattern;

  always_comb begin
    opClass                = '0;
    opClass[NUM_CBO-1:0]   = liveOps;
    opClass[CLS_QLOAD]     = fallThrough;
    opClass[CLS_OTHER]     = !(|liveOps) && !fallThrough;
  end

  assign rs1Idx    = (|liveOps) ? instrWord[RS1_LO +: REG_W] : '0;
  assign hintNop   = strobes.oriHint;
  assign quadLoad  = fallThrough;
  assign illegalOp = |blockedOps;

  always_comb begin
    assert_class_onehot_R2: assert ($onehot(opClass))
      else $error("opClass not one-hot");
    assert_no_illegal_qload_R4: assert (!(illegalOp && quadLoad))
      else $error("illegal word fell through to quad-load");
    assert_hint_is_other_R7: assert (!hintNop || (opClass[CLS_OTHER] && !illegalOp))
      else $error("hint decoded as something other than a no-op");
    assert_rs1_only_live_R6: assert ((rs1Idx == '0) || (|opClass[NUM_CBO-1:0]))
      else $error("rs1 index driven without a recognised op");
  end
endmodule

// File: rtl/cbo_op_decoder.sv
module cbo_op_decoder
  import cbo_dec_pkg::*;
#(
  parameter int ILEN = ILEN_DEF
) (
  input  logic [ILEN-1:0]    instrWord,
  input  logic               mgmtEn,
  input  logic               zeroEn,
  output logic [NUM_CLS-1:0] opClass,
  output logic [REG_W-1:0]   rs1Idx,
  output logic               hintNop,
  output logic               quadLoad,
  output logic               illegalOp
);
  cbo_strobe_t strobes;

  cbo_dec_ctrl #(.ILEN(ILEN)) u_ctrl (
    .instrWord (instrWord),
    .mgmtEn    (mgmtEn),
    .zeroEn    (zeroEn),
    .strobes   (strobes)
  );

  cbo_dec_dp #(.ILEN(ILEN)) u_dp (
    .instrWord (instrWord),
    .strobes   (strobes),
    .opClass   (opClass),
    .rs1Idx    (rs1Idx),
    .hintNop   (hintNop),
    .quadLoad  (quadLoad),
    .illegalOp (illegalOp)
  );
endmodule

// File: tb/cbo_op_decoder_tb.sv
module cbo_op_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instrWord = '0;
  logic        mgmtEn = 1'b0;
  logic        zeroEn = 1'b0;
  logic [5:0]  opClass;
  logic [4:0]  rs1Idx;
  logic        hintNop, quadLoad, illegalOp;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  cbo_op_decoder u_dut (
    .instrWord(instrWord), .mgmtEn(mgmtEn), .zeroEn(zeroEn),
    .opClass(opClass), .rs1Idx(rs1Idx), .hintNop(hintNop),
    .quadLoad(quadLoad), .illegalOp(illegalOp)
  );

  // Class bits: 0 clean, 1 flush, 2 inval, 3 zero, 4 quad-load, 5 other
  function automatic logic [31:0] mkCbo(input logic [4:0] sel, input logic [4:0] rs1);
    return {7'b0000000, sel, rs1, 3'b010, 5'b00000, 7'b0001111};
  endfunction

  task automatic apply(input logic [31:0] w, input logic m, input logic z);
    @(posedge clk);
    instrWord = w; mgmtEn = m; zeroEn = z;
    @(negedge clk);
  endtask

  task automatic expectAll(input string req, input logic [5:0] eCls, input logic [4:0] eRs1,
                           input logic eHint, input logic eQl, input logic eIll);
    checks++;
    if (opClass !== eCls || rs1Idx !== eRs1 || hintNop !== eHint ||
        quadLoad !== eQl || illegalOp !== eIll) begin
      errors++;
      $display("FAIL %s word=%h act cls=%b rs1=%0d h=%b q=%b i=%b exp cls=%b rs1=%0d h=%b q=%b i=%b",
               req, instrWord, opClass, rs1Idx, hintNop, quadLoad, illegalOp,
               eCls, eRs1, eHint, eQl, eIll);
    end
  endtask

  task automatic testReset();
    apply(32'h0, 1'b0, 1'b0);
    expectAll("R8 idle zero word", 6'b100000, 5'd0, 0, 0, 0);
  endtask

  task automatic testCboOps();
    apply(mkCbo(5'b00001, 5'd3), 1, 1);  expectAll("R1 clean",  6'b000001, 5'd3, 0, 0, 0);
    apply(mkCbo(5'b00010, 5'd17), 1, 1); expectAll("R1 flush",  6'b000010, 5'd17, 0, 0, 0);
    apply(mkCbo(5'b00000, 5'd31), 1, 1); expectAll("R1 inval",  6'b000100, 5'd31, 0, 0, 0);
    apply(mkCbo(5'b00100, 5'd9), 1, 1);  expectAll("R1 zero",   6'b001000, 5'd9, 0, 0, 0);
  endtask

  task automatic testNearMiss();
    apply(mkCbo(5'b00011, 5'd4), 1, 1); expectAll("R3 bad sel", 6'b010000, 5'd0, 0, 1, 0);
    apply(mkCbo(5'b00001, 5'd4) | 32'h0000_0080, 1, 1);
    expectAll("R3 rd nonzero", 6'b010000, 5'd0, 0, 1, 0);
    apply(mkCbo(5'b00100, 5'd4) | 32'h8000_0000, 1, 1);
    expectAll("R3 top bit set", 6'b010000, 5'd0, 0, 1, 0);
    apply(mkCbo(5'b00100, 5'd4) | 32'h0200_0000, 0, 0);
    expectAll("R3 top bit25 disabled", 6'b010000, 5'd0, 0, 1, 0);
    apply(mkCbo(5'b00001, 5'd4) ^ 32'h0000_1000, 1, 1);
    expectAll("R8 funct3 miss", 6'b100000, 5'd0, 0, 0, 0);
    apply(mkCbo(5'b00001, 5'd4) ^ 32'h0000_0001, 1, 1);
    expectAll("R8 opcode miss", 6'b100000, 5'd0, 0, 0, 0);
  endtask

  task automatic testDisabled();
    apply(mkCbo(5'b00001, 5'd5), 0, 1); expectAll("R4 clean off", 6'b100000, 5'd0, 0, 0, 1);
    apply(mkCbo(5'b00010, 5'd5), 0, 1); expectAll("R4 flush off", 6'b100000, 5'd0, 0, 0, 1);
    apply(mkCbo(5'b00000, 5'd5), 0, 1); expectAll("R4 inval off", 6'b100000, 5'd0, 0, 0, 1);
    apply(mkCbo(5'b00100, 5'd5), 0, 1); expectAll("R5 zero on mgmt off", 6'b001000, 5'd5, 0, 0, 0);
    apply(mkCbo(5'b00100, 5'd6), 1, 0); expectAll("R5 zero off", 6'b100000, 5'd0, 0, 0, 1);
    apply(mkCbo(5'b00001, 5'd7), 1, 0); expectAll("R9 clean zero-off", 6'b000001, 5'd7, 0, 0, 0);
    apply(mkCbo(5'b00010, 5'd8), 1, 0); expectAll("R9 flush zero-off", 6'b000010, 5'd8, 0, 0, 0);
  endtask

  task automatic testHints();
    apply({12'h003, 5'd10, 3'b110, 5'd0, 7'b0010011}, 1, 1);
    expectAll("R7 prefetch hint", 6'b100000, 5'd0, 1, 0, 0);
    apply({12'h001, 5'd2, 3'b110, 5'd0, 7'b0010011}, 0, 0);
    expectAll("R7 hint disabled groups", 6'b100000, 5'd0, 1, 0, 0);
    apply({12'h003, 5'd10, 3'b110, 5'd1, 7'b0010011}, 1, 1);
    expectAll("R7 ori rd!=0", 6'b100000, 5'd0, 0, 0, 0);
    apply({12'h003, 5'd10, 3'b111, 5'd0, 7'b0010011}, 1, 1);
    expectAll("R8 andi rd=0", 6'b100000, 5'd0, 0, 0, 0);
  endtask

  task automatic testRs1Sweep();
    for (int r = 0; r < 32; r++) begin
      apply(mkCbo(5'b00000, r[4:0]), 1, 1);
      expectAll("R6 rs1 sweep", 6'b000100, r[4:0], 0, 0, 0);
    end
    apply({12'hFFF, 5'd21, 3'b010, 5'd3, 7'b0001111}, 1, 1);
    expectAll("R6 qload rs1 zero", 6'b010000, 5'd0, 0, 1, 0);
  endtask

  task automatic testOneHotSweep();
    for (int i = 0; i < 64; i++) begin
      apply({7'(i), 5'(i >> 1), 5'(i), 3'b010, 5'(i & 1), 7'b0001111}, i[0], i[1]);
      checks++;
      if ($countones(opClass) != 1) begin
        errors++;
        $display("FAIL R2 onehot word=%h act=%b exp=one bit", instrWord, opClass);
      end
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    testReset();
    testCboOps();
    testNearMiss();
    testDisabled();
    testHints();
    testRs1Sweep();
    testOneHotSweep();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule